// File: doc/BRIEF.md
# Graphics Aperture Address Translator

This block maps addresses that fall inside a graphics aperture onto physical memory pages. The page table lives in system memory as one 32-bit word per page. Each word is stored little-endian; after a byte swap its upper 20 bits give the physical page frame and bit 0 marks the entry as usable. A four-way, fully associative translation cache holds recent lookups. On a miss the block issues a single read of the table word and waits for it, with its request port stalled.

Software configures the block through a write-only register port. Select 0 is the aperture base, of which only bits 31:28 count. Select 1 holds the table location in bits 31:12 and the table's entry count in bits 11:0. Select 2 is the control word, with invalidate in bit 0, enable in bit 8 and double-rate reset in bit 16. A sequencer tracks the control writes. One fixed four-write pattern flushes the cache and leaves translation on. A second pattern flushes the cache and turns translation off.

Top module: `gart_xlate`

## Requirements
- R1: After reset, req_ready, rsp_valid and mem_req are all low, and translation is off.
- R2: A control write with bit 8 set and bits 0 and 16 clear turns translation on, and req_ready rises on the next cycle.
- R3: A request whose bits 31:28 differ from the aperture base bits 31:28 gets rsp_valid with rsp_err=1 and rsp_addr=0 one cycle after acceptance, and no table read is issued.
- R4: A request whose page index (bits 27:12) is at or above the entry count in select 1 bits 11:0 gets an error response one cycle after acceptance, with no table read.
- R5: On a cache miss, mem_req pulses for one cycle right after acceptance, with mem_addr = {select1[31:12], 12'h000} + 4 × page index. req_ready stays low until the response.
- R6: The fetched word is byte-swapped (byte 0 becomes bits 31:24). The response, one cycle after mem_rvalid, carries rsp_addr = {swapped[31:12], request[11:0]}.
- R7: A fetched entry whose swapped bit 0 is clear gives an error response and is not cached, so a repeat request reads the table again.
- R8: A page translated successfully before answers one cycle after acceptance, with no table read.
- R9: With all four cache slots filled, a new fill replaces the oldest fill (round robin).
- R10: The control writes 0x101, 0x100, 0x10100, 0x100 in order flush the cache and leave translation on. req_ready is low from the first write until the cycle after the last.
- R11: The control writes 0x101, 0, 0x10000, 0 in order flush the cache and turn translation off, so requests are no longer accepted.
- R12: A write that breaks a sequence abandons it without a flush, and cached pages still hit.
- R13: Two invalidate sequences written back to back both complete, and translation resumes at once afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 aperture, 1 table, 2 control |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Translation request valid |
| req_addr | input | 32 | Aperture address to translate |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response is an error |
| rsp_addr | output | 32 | Translated physical address (0 on error) |
| mem_req | output | 1 | Table word read strobe |
| mem_addr | output | 32 | Table word byte address |
| mem_rvalid | input | 1 | Table read data valid |
| mem_rdata | input | 32 | Table word as stored in memory |

## Verification
Translation is exercised with repeated pages, which separate a hit from a refill. Five distinct pages are used to force an eviction, and the evicted page is then revisited, which shows the replacement order. An invalid entry is requested twice to show that it is never cached. Addresses outside the aperture or past the table end must never reach memory. On the control side, the bench drives the complete invalidate pattern, the complete shutdown pattern, a pattern broken in the middle and two invalidate patterns back to back, and compares the cache contents before and after each one.

// File: rtl/gart_pkg.sv
package gart_pkg;
    localparam int CTRL_INV_BIT = 0;
    localparam int CTRL_EN_BIT  = 8;
    localparam int CTRL_X2_BIT  = 16;

    // control code packed as {x2, en, inv}
    typedef logic [2:0] ctl_code_t;
    localparam ctl_code_t CC_ZERO   = 3'b000;
    localparam ctl_code_t CC_EN     = 3'b010;
    localparam ctl_code_t CC_EN_INV = 3'b011;
    localparam ctl_code_t CC_EN_X2  = 3'b110;
    localparam ctl_code_t CC_X2     = 3'b100;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_INV_A, SQ_INV_B, SQ_INV_C, SQ_OFF_B, SQ_OFF_C
    } seq_st_e;

    typedef enum logic {XL_IDLE, XL_WAIT} xl_st_e;

    function automatic logic [31:0] swap_bytes(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction
endpackage

// File: rtl/gart_ctl_seq.sv
module gart_ctl_seq
    import gart_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr,
    input  ctl_code_t code,
    output logic      busy,
    output logic      enabled,
    output logic      flush
);
    typedef struct packed {
        seq_st_e st;
        logic    en;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d     = q;
        flush = 1'b0;
        if (wr) begin
            d.en = code[1];
            if (code == CC_EN_INV) begin
                d.st = SQ_INV_A;
            end else begin
                d.st = SQ_IDLE;
                case (q.st)
                    SQ_INV_A: begin
                        if (code == CC_EN)   d.st = SQ_INV_B;
                        if (code == CC_ZERO) d.st = SQ_OFF_B;
                    end
                    SQ_INV_B: if (code == CC_EN_X2) d.st = SQ_INV_C;
                    SQ_INV_C: flush = (code == CC_EN);
                    SQ_OFF_B: if (code == CC_X2) d.st = SQ_OFF_C;
                    SQ_OFF_C: flush = (code == CC_ZERO);
                    default:  d.st = SQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st <= SQ_IDLE;
            q.en <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.st != SQ_IDLE);
    assign enabled = q.en;
endmodule

// File: rtl/gart_tlb.sv
module gart_tlb #(
    parameter int WAYS = 4,
    parameter int TAGW = 16,
    parameter int FRW  = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TAGW-1:0] lk_tag,
    output logic            hit,
    output logic [FRW-1:0]  hit_frame,
    input  logic            fill,
    input  logic [TAGW-1:0] fill_tag,
    input  logic [FRW-1:0]  fill_frame,
    input  logic            flush
);
    localparam int PTRW = (WAYS > 1) ? $clog2(WAYS) : 1;

    typedef struct packed {
        logic            vld;
        logic [TAGW-1:0] tag;
        logic [FRW-1:0]  fr;
    } ent_t;

    typedef struct packed {
        ent_t [WAYS-1:0] way;
        logic [PTRW-1:0] ptr;
    } tlb_t;

    tlb_t q, d;
    logic [WAYS-1:0] match;

    for (genvar i = 0; i < WAYS; i++) begin : g_cmp
        assign match[i] = q.way[i].vld && (q.way[i].tag == lk_tag);
    end

    always_comb begin
        hit_frame = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (match[i]) hit_frame = hit_frame | q.way[i].fr;
        end
    end
    assign hit = |match;

    always_comb begin
        d = q;
        if (flush) begin
            for (int i = 0; i < WAYS; i++) d.way[i].vld = 1'b0;
            d.ptr = '0;
        end else if (fill) begin
            d.way[q.ptr] = '{vld: 1'b1, tag: fill_tag, fr: fill_frame};
            d.ptr = (q.ptr == PTRW'(WAYS - 1)) ? '0 : q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/gart_xlate.sv
module gart_xlate
    import gart_pkg::*;
#(
    parameter int AW   = 32,
    parameter int APW  = 4,
    parameter int PGW  = 12,
    parameter int WAYS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic          rsp_err,
    output logic [AW-1:0] rsp_addr,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [AW-1:0] mem_rdata
);
    localparam int IDXW = AW - APW - PGW;
    localparam int FRW  = AW - PGW;

    typedef struct packed {
        xl_st_e          st;
        logic            rsp_v;
        logic            rsp_err;
        logic [AW-1:0]   rsp_addr;
        logic            mreq;
        logic [AW-1:0]   maddr;
        logic [IDXW-1:0] idx;
        logic [PGW-1:0]  off;
        logic            kill;
        logic [APW-1:0]  ap;
        logic [AW-1:0]   tb;
    } xl_t;

    xl_t q, d;

    logic            seq_busy, xl_enabled, flush;
    logic            tlb_hit, fill;
    logic [FRW-1:0]  hit_frame;
    logic [IDXW-1:0] idx_w;
    logic [AW-1:0]   ent;
    logic            ap_ok, in_range, accept;

    gart_ctl_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_we && cfg_sel == 2'd2),
        .code    ({cfg_wdata[CTRL_X2_BIT], cfg_wdata[CTRL_EN_BIT], cfg_wdata[CTRL_INV_BIT]}),
        .busy    (seq_busy),
        .enabled (xl_enabled),
        .flush   (flush)
    );

    gart_tlb #(.WAYS(WAYS), .TAGW(IDXW), .FRW(FRW)) u_tlb (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_tag     (idx_w),
        .hit        (tlb_hit),
        .hit_frame  (hit_frame),
        .fill       (fill),
        .fill_tag   (q.idx),
        .fill_frame (ent[AW-1:PGW]),
        .flush      (flush)
    );

    assign idx_w     = req_addr[AW-APW-1:PGW];
    assign ap_ok     = (req_addr[AW-1 -: APW] == q.ap);
    assign in_range  = (idx_w < IDXW'(q.tb[PGW-1:0]));
    assign req_ready = xl_enabled && !seq_busy && (q.st == XL_IDLE);
    assign accept    = req_valid && req_ready;
    assign ent       = swap_bytes(mem_rdata);

    always_comb begin
        d       = q;
        d.rsp_v = 1'b0;
        d.mreq  = 1'b0;
        fill    = 1'b0;
        if (q.st == XL_WAIT && mem_rvalid) begin
            d.st    = XL_IDLE;
            d.rsp_v = 1'b1;
            if (ent[0]) begin
                d.rsp_err  = 1'b0;
                d.rsp_addr = {ent[AW-1:PGW], q.off};
                fill       = !q.kill;
            end else begin
                d.rsp_err  = 1'b1;
                d.rsp_addr = '0;
            end
        end
        if (accept) begin
            if (!ap_ok || !in_range) begin
                d.rsp_v    = 1'b1;
                d.rsp_err  = 1'b1;
                d.rsp_addr = '0;
            end else if (tlb_hit) begin
                d.rsp_v    = 1'b1;
                d.rsp_err  = 1'b0;
                d.rsp_addr = {hit_frame, req_addr[PGW-1:0]};
            end else begin
                d.st    = XL_WAIT;
                d.mreq  = 1'b1;
                d.maddr = {q.tb[AW-1:PGW], {PGW{1'b0}}} + AW'({idx_w, 2'b00});
                d.idx   = idx_w;
                d.off   = req_addr[PGW-1:0];
                d.kill  = 1'b0;
            end
        end
        if (flush) d.kill = 1'b1;
        if (cfg_we && cfg_sel == 2'd0) d.ap = cfg_wdata[AW-1 -: APW];
        if (cfg_we && cfg_sel == 2'd1) d.tb = cfg_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= XL_IDLE;
        end else begin
            q <= d;
        end
    end

    assign rsp_valid = q.rsp_v;
    assign rsp_err   = q.rsp_err;
    assign rsp_addr  = q.rsp_addr;
    assign mem_req   = q.mreq;
    assign mem_addr  = q.maddr;
endmodule

// File: rtl/gart_xlate_chk.sv
module gart_xlate_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_valid,
    input logic mem_req,
    input logic mem_rvalid,
    input logic seq_busy,
    input logic xl_enabled
);
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!req_ready && !rsp_valid && !mem_req));

    a_r5_read_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    a_r5_stall_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    a_r8_rsp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_rvalid)));

    a_r10_stall_in_sequence: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> !req_ready);

    a_r11_stall_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_enabled |-> !req_ready);
endmodule

bind gart_xlate gart_xlate_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .mem_req    (mem_req),
    .mem_rvalid (mem_rvalid),
    .seq_busy   (seq_busy),
    .xl_enabled (xl_enabled)
);

// File: tb/gart_xlate_test.sv
module gart_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready, rsp_valid, rsp_err, mem_req;
    logic [31:0] rsp_addr, mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int    checks = 0, fails = 0;
    string cur_req = "R1";
    bit    started = 1'b0;

    localparam logic [31:0] TBL = 32'h0010_0000;

    always #10 clk = ~clk;

    gart_xlate uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_addr(rsp_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] bsw(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    // logical table entry: frame 0x80000 + 0x11*i, entry 5 not usable
    function automatic logic [31:0] logical_entry(input int i);
        logic [19:0] fr = 20'h80000 + 20'(i * 17);
        return {fr, 11'd0, (i == 5) ? 1'b0 : 1'b1};
    endfunction

    // ---------------- memory responder (3-cycle latency) ----------------
    int          lat = -1;
    logic [31:0] lat_addr;
    always @(negedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            lat = 3;
            lat_addr = mem_addr;
        end else if (lat > 0) begin
            lat--;
            if (lat == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= bsw(logical_entry(int'((lat_addr - TBL) >> 2)));
                lat = -1;
            end
        end
    end

    // ---------------- behavioural reference model ----------------
    bit          m_en, m_wait, m_kill;
    int          m_idx;
    logic [11:0] m_off;
    logic [3:0]  m_ap;
    logic [31:0] m_tb;
    int          q_tag[$];
    logic [19:0] q_fr[$];
    logic [2:0]  hist[$];
    bit          e_rv, e_err, e_mreq;
    logic [31:0] e_addr, e_maddr;

    function automatic bit pat_match(input logic [2:0] h[$], input logic [2:0] p[4], output bit full);
        full = (h.size() == 4);
        for (int k = 0; k < h.size(); k++) if (h[k] != p[k]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit m_ready();
        return m_en && hist.size() == 0 && !m_wait;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_wait = 0; m_kill = 0; m_ap = 0; m_tb = 0;
            q_tag.delete(); q_fr.delete(); hist.delete();
            e_rv = 0; e_err = 0; e_addr = 0; e_mreq = 0; e_maddr = 0;
        end else begin
            automatic bit rdy = m_ready();
            automatic logic [31:0] sw;
            e_rv = 0; e_mreq = 0;
            if (m_wait && mem_rvalid) begin
                sw = bsw(mem_rdata);
                m_wait = 0; e_rv = 1;
                if (sw[0]) begin
                    e_err = 0; e_addr = {sw[31:12], m_off};
                    if (!m_kill) begin
                        if (q_tag.size() == 4) begin void'(q_tag.pop_front()); void'(q_fr.pop_front()); end
                        q_tag.push_back(m_idx); q_fr.push_back(sw[31:12]);
                    end
                end else begin
                    e_err = 1; e_addr = 0;
                end
            end
            if (req_valid && rdy) begin
                automatic int ix = int'(req_addr[27:12]);
                automatic int hp = -1;
                foreach (q_tag[k]) if (q_tag[k] == ix) hp = k;
                if (req_addr[31:28] != m_ap || ix >= int'(m_tb[11:0])) begin
                    e_rv = 1; e_err = 1; e_addr = 0;
                end else if (hp >= 0) begin
                    e_rv = 1; e_err = 0; e_addr = {q_fr[hp], req_addr[11:0]};
                end else begin
                    e_mreq = 1; e_maddr = {m_tb[31:12], 12'h0} + 32'(4 * ix);
                    m_wait = 1; m_kill = 0; m_idx = ix; m_off = req_addr[11:0];
                end
            end
            if (cfg_we && cfg_sel == 2'd0) m_ap = cfg_wdata[31:28];
            if (cfg_we && cfg_sel == 2'd1) m_tb = cfg_wdata;
            if (cfg_we && cfg_sel == 2'd2) begin
                automatic logic [2:0] c = {cfg_wdata[16], cfg_wdata[8], cfg_wdata[0]};
                automatic logic [2:0] pi[4] = '{3'b011, 3'b010, 3'b110, 3'b010};
                automatic logic [2:0] po[4] = '{3'b011, 3'b000, 3'b100, 3'b000};
                automatic bit fi, fo;
                m_en = c[1];
                hist.push_back(c);
                if ((pat_match(hist, pi, fi) && fi) || (pat_match(hist, po, fo) && fo)) begin
                    q_tag.delete(); q_fr.delete(); hist.delete();
                    if (m_wait) m_kill = 1;
                end else if (!pat_match(hist, pi, fi) && !pat_match(hist, po, fo)) begin
                    hist.delete();
                    if (c == 3'b011) hist.push_back(c);
                end
            end
            started = 1'b1;
        end
    end

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (started && rst_n) begin
            checks++;
            if (req_ready !== m_ready() || rsp_valid !== e_rv || mem_req !== e_mreq ||
                (e_rv && (rsp_err !== e_err || rsp_addr !== e_addr)) ||
                (e_mreq && mem_addr !== e_maddr)) begin
                fails++;
                $display("FAIL %s model: ready=%0b/%0b rv=%0b/%0b err=%0b/%0b addr=%h/%h mreq=%0b/%0b maddr=%h/%h",
                         cur_req, req_ready, m_ready(), rsp_valid, e_rv, rsp_err, e_err,
                         rsp_addr, e_addr, mem_req, e_mreq, mem_addr, e_maddr);
            end
        end
    end

    // ---------------- tasks ----------------
    task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [31:0] v);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // issue one request and check its response against bench-computed values
    task automatic do_req(input string r, input int idx, input logic [3:0] top, input bit exp_miss);
        automatic logic [31:0] a = {top, 16'(idx), 12'h5A4};
        automatic logic [31:0] le = logical_entry(idx);
        automatic bit exp_err = (top != 4'hA) || idx >= 8 || !le[0];
        automatic bit miss_seen = 1'b0;
        automatic int n = 0;
        req_valid = 1'b1; req_addr = a;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && n < 40) begin
            if (mem_req) begin
                miss_seen = 1'b1;
                check(r, mem_addr, TBL + 32'(4 * idx));
            end
            @(negedge clk); n++;
        end
        check(r, 32'(rsp_valid), 32'd1);
        check(r, 32'(miss_seen), 32'(exp_miss));
        check(r, 32'(rsp_err), 32'(exp_err));
        check(r, rsp_addr, exp_err ? 32'h0 : {le[31:12], 12'h5A4});
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        check("R1", {29'd0, req_ready, rsp_valid, mem_req}, 32'd0);

        cur_req = "R2";
        cfg_write(2'd0, 32'hA123_4567);
        cfg_write(2'd1, TBL | 32'd8);
        check("R2", 32'(req_ready), 32'd0);
        cfg_write(2'd2, 32'h100);
        check("R2", 32'(req_ready), 32'd1);

        cur_req = "R5"; do_req("R5", 0, 4'hA, 1);
        cur_req = "R8"; do_req("R8", 0, 4'hA, 0);
        cur_req = "R6"; do_req("R6", 1, 4'hA, 1);
        do_req("R6", 2, 4'hA, 1);
        do_req("R6", 3, 4'hA, 1);
        cur_req = "R9"; do_req("R9", 4, 4'hA, 1);
        do_req("R9", 3, 4'hA, 0);
        do_req("R9", 0, 4'hA, 1);
        cur_req = "R7"; do_req("R7", 5, 4'hA, 1);
        do_req("R7", 5, 4'hA, 1);
        cur_req = "R4"; do_req("R4", 8, 4'hA, 0);
        cur_req = "R3"; do_req("R3", 1, 4'hB, 0);

        cur_req = "R12";
        cfg_write(2'd2, 32'h101);
        check("R12", 32'(req_ready), 32'd0);
        cfg_write(2'd2, 32'h10100);
        check("R12", 32'(req_ready), 32'd1);
        do_req("R12", 4, 4'hA, 0);

        cur_req = "R10";
        cfg_write(2'd2, 32'h101);
        check("R10", 32'(req_ready), 32'd0);
        cfg_write(2'd2, 32'h100);
        check("R10", 32'(req_ready), 32'd0);
        cfg_write(2'd2, 32'h10100);
        check("R10", 32'(req_ready), 32'd0);
        cfg_write(2'd2, 32'h100);
        check("R10", 32'(req_ready), 32'd1);
        do_req("R10", 4, 4'hA, 1);
        do_req("R10", 4, 4'hA, 0);

        cur_req = "R13";
        for (int k = 0; k < 2; k++) begin
            cfg_write(2'd2, 32'h101);
            cfg_write(2'd2, 32'h100);
            cfg_write(2'd2, 32'h10100);
            cfg_write(2'd2, 32'h100);
        end
        check("R13", 32'(req_ready), 32'd1);
        do_req("R13", 4, 4'hA, 1);

        cur_req = "R11";
        cfg_write(2'd2, 32'h101);
        cfg_write(2'd2, 32'h0);
        cfg_write(2'd2, 32'h10000);
        cfg_write(2'd2, 32'h0);
        req_valid = 1'b1; req_addr = 32'hA000_2000;
        for (int k = 0; k < 5; k++) begin
            check("R11", {30'd0, req_ready, rsp_valid}, 32'd0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        cfg_write(2'd2, 32'h100);
        do_req("R11", 4, 4'hA, 1);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule